// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog that runs from a slow 32 kHz tick and sits behind a small 32-bit register port. The port has a write strobe, a byte address, write data and combinational read data. Every write that changes behaviour must carry a fixed key value in a known field, so a stray store cannot disarm the watchdog or change its interval. Writes with the wrong key are dropped.

Software programs a timeout length, enables the watchdog and then reloads ("kicks") it at intervals by writing a key word. If the countdown reaches its end, the block raises a reset request for a fixed number of slow cycles and records the cause. A second key word forces the same reset at once. The reset also drives an optional external pin at a chosen polarity. An interrupt output reflects the recorded cause when the interrupt is enabled.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the mode register reads 0, the length register reads 0xFFFF_FFE0 (all-ones length in bits [31:5], zero below), the status register reads 0, and sys_rst, ext_rst_pin and irq are all 0.
- R2: A write to the mode register (offset 0x00) is accepted only when wdata[31:24] = 0x22. It then loads bit 0 = run, bit 1 = pin polarity (1 means the pin is active-low), bit 2 = pin enable and bit 3 = interrupt enable, and reads back as those four bits in [3:0]. A mode write with any other key changes nothing.
- R3: A write to the length register (offset 0x04) is accepted only when wdata[4:0] = 0x08. It then stores wdata[31:5] as the timeout length, which reads back in [31:5] with zeros in [4:0]. A write with any other low field changes nothing.
- R4: While running with length N ≥ 1, sys_rst rises exactly N × PRESCALE (512) clock cycles after the clock edge that accepted a restart write, and not one cycle earlier.
- R5: Each reset event holds sys_rst high for exactly PULSE_LEN (16) consecutive cycles.
- R6: An expiry sets status bit 31 (offset 0x0C). Expiry reloads the count with the stored length, and the watchdog keeps counting.
- R7: Writing exactly 0x0000_1971 to offset 0x08 reloads the count from the stored length and restarts the 512-cycle prescaler. Kicking more often than the timeout prevents any expiry.
- R8: When run is cleared, the count and prescaler freeze and no expiry occurs. Setting run again resumes counting from the frozen point.
- R9: Writing exactly 0x0000_1209 to offset 0x14 raises sys_rst on the next cycle and sets status bit 30, whether or not the watchdog is running.
- R10: Any accepted mode write clears both status bits. A mode write with a bad key leaves them set.
- R11: ext_rst_pin equals the polarity bit when idle. When pin enable is set, it takes the opposite level while sys_rst is high. When pin enable is clear, it stays at the polarity level.
- R12: irq is high exactly when interrupt enable is set and at least one status bit is set.
- R13: A length written while counting does not change the current countdown. It takes effect at the next restart write.
- R14: A write to the restart or software-reset offset with any value other than its key word is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | ADDR_W (8) | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| sys_rst | output | 1 | Active-high reset request, PULSE_LEN cycles per event |
| ext_rst_pin | output | 1 | External reset pin at the programmed polarity |
| irq | output | 1 | Interrupt: enabled and a status bit set |

## Verification
The timeout path is driven in three ways: a plain run to expiry, a run kicked steadily well inside the interval, and a run paused and resumed. Together these show whether the count, the reload and the freeze sit on the right cycle, down to a one-cycle error at the expiry edge. Each key check is paired with a near-miss value (a wrong key byte, a wrong low field, a kick or reset word off by one), so a decoder that tests too few bits is caught. A length change in mid-count, followed by a kick, separates live use of the length from its latched use. The three pin settings separate polarity from pin enable.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned LEN_LSB = 5;
    localparam int unsigned LEN_W = DATA_W - LEN_LSB;

    localparam logic [7:0] OFS_MODE  = 8'h00;
    localparam logic [7:0] OFS_LEN   = 8'h04;
    localparam logic [7:0] OFS_KICK  = 8'h08;
    localparam logic [7:0] OFS_STAT  = 8'h0C;
    localparam logic [7:0] OFS_SWRST = 8'h14;

    localparam logic [7:0]         MODE_KEY  = 8'h22;
    localparam logic [LEN_LSB-1:0] LEN_KEY   = 5'h08;
    localparam logic [DATA_W-1:0]  KICK_KEY  = 32'h0000_1971;
    localparam logic [DATA_W-1:0]  SWRST_KEY = 32'h0000_1209;

    // field order matches the mode register bits [3:0]
    typedef struct packed {
        logic irq_en;
        logic pin_en;
        logic pin_low;
        logic run;
    } mode_t;

    // field order matches status bits [31:30]
    typedef struct packed {
        logic by_timeout;
        logic by_software;
    } cause_t;

endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
    import wdk_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                tmo_evt,
    output mode_t               mode,
    output logic [LEN_W-1:0]    len,
    output logic                kick,
    output logic                swrst,
    output cause_t              cause,
    output logic [DATA_W-1:0]   rdata
);

    typedef struct packed {
        mode_t             mode;
        logic [LEN_W-1:0]  len;
        cause_t            cause;
    } regs_t;

    regs_t q, d;
    logic  sel_mode, sel_len, sel_kick, sel_stat, sel_swrst;
    logic  hit_mode, hit_len;

    always_comb begin
        sel_mode  = (addr == ADDR_W'(OFS_MODE));
        sel_len   = (addr == ADDR_W'(OFS_LEN));
        sel_kick  = (addr == ADDR_W'(OFS_KICK));
        sel_stat  = (addr == ADDR_W'(OFS_STAT));
        sel_swrst = (addr == ADDR_W'(OFS_SWRST));

        hit_mode = wr_en && sel_mode && (wdata[DATA_W-1 -: 8] == MODE_KEY);
        hit_len  = wr_en && sel_len  && (wdata[LEN_LSB-1:0] == LEN_KEY);
        kick     = wr_en && sel_kick  && (wdata == KICK_KEY);
        swrst    = wr_en && sel_swrst && (wdata == SWRST_KEY);

        d = q;
        if (hit_mode) begin
            d.mode  = mode_t'(wdata[3:0]);
            d.cause = '0;
        end
        if (hit_len) begin
            d.len = wdata[DATA_W-1:LEN_LSB];
        end
        if (tmo_evt) begin
            d.cause.by_timeout = 1'b1;
        end
        if (swrst) begin
            d.cause.by_software = 1'b1;
        end

        if (sel_mode) begin
            rdata = {{(DATA_W-4){1'b0}}, q.mode};
        end else if (sel_len) begin
            rdata = {q.len, {LEN_LSB{1'b0}}};
        end else if (sel_stat) begin
            rdata = {q.cause, {(DATA_W-2){1'b0}}};
        end else begin
            rdata = '0;
        end

        mode  = q.mode;
        len   = q.len;
        cause = q.cause;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode  <= '0;
            q.len   <= '1;
            q.cause <= '0;
        end else begin
            q <= d;
        end
    end

    a_r2_bad_mode_key: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_mode && (wdata[DATA_W-1 -: 8] != MODE_KEY)) |=> $stable(q.mode));

    a_r3_bad_len_key: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_len && (wdata[LEN_LSB-1:0] != LEN_KEY)) |=> $stable(q.len));

    a_r9_sw_flag: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |=> q.cause.by_software);

    a_r10_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_mode && !tmo_evt && !swrst) |=> (q.cause == '0));

endmodule

// File: rtl/wdk_counter.sv
module wdk_counter
    import wdk_pkg::*;
#(
    parameter int unsigned PRESCALE = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               kick,
    input  logic [LEN_W-1:0]   len,
    output logic               expire
);

    localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic [PRE_W-1:0] pre;
    } cnt_t;

    cnt_t q, d;

    always_comb begin
        d      = q;
        expire = 1'b0;
        if (kick) begin
            d.cnt = len;
            d.pre = '0;
        end else if (run) begin
            if (q.pre == PRE_LAST) begin
                d.pre = '0;
                if (q.cnt <= LEN_W'(1)) begin
                    expire = 1'b1;
                    d.cnt  = len;
                end else begin
                    d.cnt = q.cnt - LEN_W'(1);
                end
            end else begin
                d.pre = q.pre + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= '1;
            q.pre <= '0;
        end else begin
            q <= d;
        end
    end

    a_r8_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !kick) |=> ($stable(q.cnt) && $stable(q.pre)));

    a_r7_kick_reload: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> ((q.cnt == $past(len)) && (q.pre == '0)));

    a_r13_no_live_len: assert property (@(posedge clk) disable iff (!rst_n)
        (!kick && !expire) |=> (q.cnt <= $past(q.cnt)));

endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic pin_en,
    input  logic pin_low,
    output logic sys_rst,
    output logic ext_rst_pin
);

    localparam int unsigned PW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [PW-1:0] left;
    } pulse_t;

    pulse_t q, d;

    always_comb begin
        d = q;
        if (fire) begin
            d.left = PW'(PULSE_LEN);
        end else if (q.left != '0) begin
            d.left = q.left - PW'(1);
        end
        sys_rst     = (q.left != '0);
        ext_rst_pin = (pin_en & sys_rst) ^ pin_low;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.left <= '0;
        end else begin
            q <= d;
        end
    end

    a_r5_fire_asserts: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> sys_rst);

    a_r5_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst && !fire) |=> (q.left < $past(q.left)));

    a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        q.left <= PW'(PULSE_LEN));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdk_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned PRESCALE  = 512,
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic               sys_rst,
    output logic               ext_rst_pin,
    output logic               irq
);

    mode_t            mode;
    cause_t           cause;
    logic [LEN_W-1:0] len;
    logic             kick, swrst, expire;

    wdk_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .tmo_evt (expire),
        .mode    (mode),
        .len     (len),
        .kick    (kick),
        .swrst   (swrst),
        .cause   (cause),
        .rdata   (rdata)
    );

    wdk_counter #(.PRESCALE(PRESCALE)) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (mode.run),
        .kick   (kick),
        .len    (len),
        .expire (expire)
    );

    wdk_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (expire | swrst),
        .pin_en      (mode.pin_en),
        .pin_low     (mode.pin_low),
        .sys_rst     (sys_rst),
        .ext_rst_pin (ext_rst_pin)
    );

    assign irq = mode.irq_en & (|cause);

    a_r6_expiry_flag: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cause.by_timeout && sys_rst));

    a_r8_no_expiry_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode.run && !swrst && !sys_rst) |=> !sys_rst);

endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;

    localparam int P  = 512;
    localparam int PL = 16;
    localparam logic [7:0] A_MODE = 8'h00, A_LEN = 8'h04, A_KICK = 8'h08,
                           A_STAT = 8'h0C, A_SW = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sys_rst, ext_rst_pin, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    keyed_watchdog uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .sys_rst(sys_rst), .ext_rst_pin(ext_rst_pin), .irq(irq)
    );

    always #4ns clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1ns;
        v = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 sys_rst", 32'(sys_rst), 0);
        chk("R1 pin", 32'(ext_rst_pin), 0);
        chk("R1 irq", 32'(irq), 0);
        rd(A_MODE, v); chk("R1 mode", v, 0);
        rd(A_LEN, v);  chk("R1 len", v, 32'hFFFF_FFE0);
        rd(A_STAT, v); chk("R1 status", v, 0);
    endtask

    task automatic t_keys();
        logic [31:0] v;
        wr(A_MODE, 32'h2100_0001);
        rd(A_MODE, v); chk("R2 bad mode key", v, 0);
        wr(A_MODE, 32'h2200_000F);
        rd(A_MODE, v); chk("R2 good mode key", v, 32'h0000_000F);
        wr(A_MODE, 32'h2200_0000);
        wr(A_LEN, 32'h0000_0047);
        rd(A_LEN, v); chk("R3 bad len key", v, 32'hFFFF_FFE0);
        wr(A_LEN, 32'h0000_0068);
        rd(A_LEN, v); chk("R3 good len key", v, 32'h0000_0060);
        wr(A_SW, 32'h0000_1208);
        chk("R14 bad swrst word", 32'(sys_rst), 0);
        rd(A_STAT, v); chk("R14 bad swrst status", v, 0);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        wr(A_LEN, 32'h0000_0048);
        wr(A_MODE, 32'h2200_0001);
        wr(A_KICK, 32'h0000_1971);
        idle(2*P - 1);
        chk("R4 before expiry", 32'(sys_rst), 0);
        idle(1);
        chk("R4 at expiry", 32'(sys_rst), 1);
        rd(A_STAT, v); chk("R6 timeout flag", v, 32'h8000_0000);
        idle(PL - 1);
        chk("R5 last pulse cycle", 32'(sys_rst), 1);
        idle(1);
        chk("R5 pulse ended", 32'(sys_rst), 0);
        wr(A_MODE, 32'h2200_0000);
        rd(A_STAT, v); chk("R10 cleared by mode write", v, 0);
    endtask

    task automatic t_kick();
        logic [31:0] v;
        wr(A_MODE, 32'h2200_0001);
        wr(A_KICK, 32'h0000_1971);
        for (int i = 0; i < 5; i++) begin
            idle(2*P - 10);
            wr(A_KICK, 32'h0000_1971);
        end
        rd(A_STAT, v); chk("R7 kicks prevent expiry", v, 0);
        idle(100);
        wr(A_KICK, 32'h0000_1972);
        idle(2*P - 1 - 101);
        chk("R14 bad kick ignored, before", 32'(sys_rst), 0);
        idle(1);
        chk("R14 bad kick ignored, expiry", 32'(sys_rst), 1);
        wr(A_MODE, 32'h2200_0000);
        idle(PL + 4);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        wr(A_LEN, 32'h0000_0028);
        wr(A_MODE, 32'h2200_0001);
        wr(A_KICK, 32'h0000_1971);
        wr(A_MODE, 32'h2200_0000);
        idle(3*P);
        chk("R8 no reset while off", 32'(sys_rst), 0);
        rd(A_STAT, v); chk("R8 no flag while off", v, 0);
        wr(A_MODE, 32'h2200_0001);
        idle(P - 2);
        chk("R8 resume, before", 32'(sys_rst), 0);
        idle(1);
        chk("R8 resume from frozen point", 32'(sys_rst), 1);
        wr(A_MODE, 32'h2200_0000);
        idle(PL + 4);
    endtask

    task automatic t_swrst();
        logic [31:0] v;
        wr(A_SW, 32'h0000_1209);
        chk("R9 immediate reset", 32'(sys_rst), 1);
        rd(A_STAT, v); chk("R9 software flag", v, 32'h4000_0000);
        idle(PL - 1);
        chk("R5 sw pulse last", 32'(sys_rst), 1);
        idle(1);
        chk("R5 sw pulse ended", 32'(sys_rst), 0);
        wr(A_MODE, 32'h2300_0000);
        rd(A_STAT, v); chk("R10 bad key keeps status", v, 32'h4000_0000);
        wr(A_MODE, 32'h2200_0000);
        rd(A_STAT, v); chk("R10 good key clears status", v, 0);
    endtask

    task automatic t_pin();
        wr(A_MODE, 32'h2200_0004);
        chk("R11 high-active idle", 32'(ext_rst_pin), 0);
        wr(A_SW, 32'h0000_1209);
        chk("R11 high-active asserted", 32'(ext_rst_pin), 1);
        idle(PL + 2);
        wr(A_MODE, 32'h2200_0006);
        chk("R11 low-active idle", 32'(ext_rst_pin), 1);
        wr(A_SW, 32'h0000_1209);
        chk("R11 low-active asserted", 32'(ext_rst_pin), 0);
        idle(PL + 2);
        wr(A_MODE, 32'h2200_0002);
        wr(A_SW, 32'h0000_1209);
        chk("R11 pin disabled sys_rst", 32'(sys_rst), 1);
        chk("R11 pin disabled holds", 32'(ext_rst_pin), 1);
        idle(PL + 2);
    endtask

    task automatic t_irq();
        wr(A_MODE, 32'h2200_0000);
        wr(A_SW, 32'h0000_1209);
        chk("R12 irq masked", 32'(irq), 0);
        idle(PL + 2);
        wr(A_MODE, 32'h2200_0008);
        chk("R12 irq after clear", 32'(irq), 0);
        wr(A_SW, 32'h0000_1209);
        chk("R12 irq raised", 32'(irq), 1);
        idle(PL + 2);
        wr(A_MODE, 32'h2200_0008);
        chk("R12 irq cleared", 32'(irq), 0);
        wr(A_MODE, 32'h2200_0000);
    endtask

    task automatic t_len_live();
        wr(A_LEN, 32'h0000_0088);
        wr(A_MODE, 32'h2200_0001);
        wr(A_KICK, 32'h0000_1971);
        idle(100);
        wr(A_LEN, 32'h0000_0028);
        idle(4*P - 1 - 101);
        chk("R13 old length, before", 32'(sys_rst), 0);
        idle(1);
        chk("R13 old length expiry", 32'(sys_rst), 1);
        idle(PL + 4);
        wr(A_KICK, 32'h0000_1971);
        idle(P - 1);
        chk("R13 new length, before", 32'(sys_rst), 0);
        idle(1);
        chk("R13 new length after kick", 32'(sys_rst), 1);
        wr(A_MODE, 32'h2200_0000);
        idle(PL + 4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_keys();
        t_timeout();
        t_kick();
        t_disable();
        t_swrst();
        t_pin();
        t_irq();
        t_len_live();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule